// File: doc/BRIEF.md
# Banked Data Pointer Register Set

This block keeps eight independent 16-bit data pointers behind a small select register. The core still sees a single data pointer: it reads and writes the pointer bytes at the usual low-byte and high-byte special-function addresses, loads a 16-bit immediate, or increments the pointer. Every one of these actions lands on whichever pointer the select register currently names. The remaining seven pointers keep their contents. Firmware can therefore keep source and destination addresses in separate pointers. It changes between them with one register write and never has to save or restore a pointer through memory.

The active pointer is always present on a 16-bit output for address generation. A combinational readback port returns the select register or the active pointer bytes for the special-function address on the bus.

Top module: `dptr_bank`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the select register and all eight pointers to zero, so `ptr_out`, `sfr_rdata` at 92h, 82h and 83h all read 00h/0000h afterwards.
- R2: A write to address 92h stores `sfr_wdata[2:0]` as the select value. Bits 7..3 are not stored, and a read of 92h returns them as zero.
- R3: A read of 82h returns bits 7..0 and a read of 83h returns bits 15..8 of the active pointer. Any other address returns 00h with `sfr_hit` low. `sfr_hit` is high for 82h, 83h and 92h.
- R4: A pointer that is not selected keeps its value through loads, increments, byte writes and select changes aimed elsewhere.
- R5: With `ld_en` high, the active pointer takes `ld_value` at the clock edge, and `ptr_out` shows it from the next cycle.
- R6: With `inc_en` high, the active pointer increases by one. The carry passes from the low byte into the high byte, and FFFFh wraps to 0000h.
- R7: A write to 82h or 83h replaces only that byte of the active pointer. In the same cycle it overrides both a load and an increment, and the other byte holds.
- R8: When `ld_en` and `inc_en` are both high, the load wins and no increment is applied.
- R9: When a select write and a load or increment share a cycle, the operation acts on the pointer that was selected before the write. The new selection drives `ptr_out` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Special-function register address for read and write |
| sfr_we | input | 1 | Write strobe for `sfr_addr` |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| sfr_hit | output | 1 | `sfr_addr` decodes to a register of this block |
| ld_en | input | 1 | Load `ld_value` into the active pointer |
| ld_value | input | 16 | Immediate value for the load |
| inc_en | input | 1 | Increment the active pointer |
| ptr_out | output | 16 | Current value of the active pointer |

## Verification
The assertions assume that reset holds for at least one clock edge and that only one special-function address is on the bus per cycle. That single address means a select write and a byte write never share a cycle. They also assume that the load and increment strobes are plain one-cycle qualifiers with no ordering among them. The stimulus drives one transaction per cycle on one address and combines load, increment and byte writes deliberately. It places select writes beside loads to reach the ordering of R9, and revisits every pointer after changes to the others.

// File: rtl/dptr_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding for the banked pointer set.
// Assumes: one operation per cycle is applied to the active pointer.
package dptr_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WR_LO = 3'd1,
        OP_WR_HI = 3'd2,
        OP_LOAD  = 3'd3,
        OP_INC   = 3'd4
    } dptr_op_e;
endpackage

// File: rtl/dptr_sel_reg.sv
`timescale 1ns/1ps
// Module: dptr_sel_reg
// Holds the pointer select value. Only SEL_W bits are stored, so
// upper write bits are dropped. Assumes a synchronous active-low reset.
module dptr_sel_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q
);
    // Capture a new selection on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wdata;
    end
endmodule

// File: rtl/dptr_ctrl.sv
`timescale 1ns/1ps
// Module: dptr_ctrl
// Picks the single operation for the active pointer (byte write beats
// load, load beats increment) and forms its next value.
// Assumes at most one of wr_lo/wr_hi is high (single SFR address).
module dptr_ctrl
    import dptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BYTE_W = PTR_W / 2
) (
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_value,
    input  logic              inc_en,
    input  logic [PTR_W-1:0]  cur_value,
    output dptr_op_e          op,
    output logic              upd,
    output logic [PTR_W-1:0]  next_value
);
    // Priority selection of the operation for this cycle.
    always_comb begin
        if (wr_lo)       op = OP_WR_LO;
        else if (wr_hi)  op = OP_WR_HI;
        else if (ld_en)  op = OP_LOAD;
        else if (inc_en) op = OP_INC;
        else             op = OP_NONE;
    end

    // Next pointer value for the chosen operation.
    always_comb begin
        case (op)
            OP_WR_LO: next_value = {cur_value[PTR_W-1:BYTE_W], wdata};
            OP_WR_HI: next_value = {wdata, cur_value[BYTE_W-1:0]};
            OP_LOAD:  next_value = ld_value;
            OP_INC:   next_value = cur_value + PTR_W'(1);
            default:  next_value = cur_value;
        endcase
    end

    assign upd = (op != OP_NONE);

    // R7: a byte write never coexists with a second byte write.
    a_r7_single_byte_wr: assert property (@(posedge upd) 1'b1 |-> !(wr_lo && wr_hi));
endmodule

// File: rtl/dptr_slot.sv
`timescale 1ns/1ps
// Module: dptr_slot
// One pointer register. It takes next_value when upd is high and
// clears on reset. Assumes upd is only given to the selected slot.
module dptr_slot #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [PTR_W-1:0] next_value,
    output logic [PTR_W-1:0] value_q
);
    // Store an update for this slot, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else if (upd)
            value_q <= next_value;
    end
endmodule

// File: rtl/dptr_bank.sv
`timescale 1ns/1ps
// Module: dptr_bank (top)
// Eight banked data pointers behind a select register. Decodes SFR
// accesses, applies the operation to the selected slot and muxes the
// active pointer to ptr_out and to the readback port.
// Assumes one SFR address per cycle and a synchronous active-low reset.
module dptr_bank
    import dptr_pkg::*;
#(
    parameter int         NUM_PTRS = 8,
    parameter int         PTR_W    = 16,
    parameter logic [7:0] SEL_ADDR = 8'h92,
    parameter logic [7:0] LO_ADDR  = 8'h82,
    parameter logic [7:0] HI_ADDR  = 8'h83
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       sfr_addr,
    input  logic             sfr_we,
    input  logic [7:0]       sfr_wdata,
    output logic [7:0]       sfr_rdata,
    output logic             sfr_hit,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_value,
    input  logic             inc_en,
    output logic [PTR_W-1:0] ptr_out
);
    localparam int SEL_W  = $clog2(NUM_PTRS);
    localparam int BYTE_W = PTR_W / 2;

    logic             sel_wr, lo_wr, hi_wr, ptr_byte_wr;
    logic [SEL_W-1:0] sel_q;
    logic [PTR_W-1:0] slot_q [NUM_PTRS];
    logic [PTR_W-1:0] active;
    logic [PTR_W-1:0] next_value;
    logic             upd;
    dptr_op_e         op;

    // Address decode of write strobes.
    always_comb begin
        sel_wr      = sfr_we && (sfr_addr == SEL_ADDR);
        lo_wr       = sfr_we && (sfr_addr == LO_ADDR);
        hi_wr       = sfr_we && (sfr_addr == HI_ADDR);
        ptr_byte_wr = lo_wr || hi_wr;
    end

    dptr_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel_wr),
        .wdata (sfr_wdata[SEL_W-1:0]),
        .sel_q (sel_q)
    );

    dptr_ctrl #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ctrl (
        .wr_lo      (lo_wr),
        .wr_hi      (hi_wr),
        .wdata      (sfr_wdata[BYTE_W-1:0]),
        .ld_en      (ld_en),
        .ld_value   (ld_value),
        .inc_en     (inc_en),
        .cur_value  (active),
        .op         (op),
        .upd        (upd),
        .next_value (next_value)
    );

    for (genvar i = 0; i < NUM_PTRS; i++) begin : g_slot
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        logic slot_upd;
        assign slot_upd = upd && (sel_q == IDX);

        dptr_slot #(.PTR_W(PTR_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd        (slot_upd),
            .next_value (next_value),
            .value_q    (slot_q[i])
        );

        // R4: a slot that is not selected holds its value.
        a_r4_idle_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && sel_q != IDX) |=> $stable(slot_q[i]));
        // R9: a load beside a select write goes to the old selection.
        a_r9_load_old_sel: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && sel_q == IDX && sel_wr && ld_en) |=> slot_q[i] == $past(ld_value));
    end

    // Active pointer mux.
    always_comb begin
        active = slot_q[0];
        for (int k = 1; k < NUM_PTRS; k++)
            if (sel_q == SEL_W'(k)) active = slot_q[k];
    end

    assign ptr_out = active;

    // Combinational readback for the addressed register.
    always_comb begin
        sfr_hit   = 1'b1;
        sfr_rdata = '0;
        case (sfr_addr)
            SEL_ADDR: sfr_rdata = {{(8-SEL_W){1'b0}}, sel_q};
            LO_ADDR:  sfr_rdata = active[BYTE_W-1:0];
            HI_ADDR:  sfr_rdata = active[PTR_W-1:BYTE_W];
            default:  sfr_hit   = 1'b0;
        endcase
    end

    // R2: a select write takes its low bits as the new selection.
    a_r2_sel_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sel_wr) |=> sel_q == $past(sfr_wdata[SEL_W-1:0]));
    // R5: an unopposed load appears on ptr_out next cycle.
    a_r5_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ld_en && !ptr_byte_wr && !sel_wr) |=> ptr_out == $past(ld_value));
    // R6: an unopposed increment adds one with wrap.
    a_r6_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && inc_en && !ld_en && !ptr_byte_wr && !sel_wr)
        |=> ptr_out == ($past(ptr_out) + PTR_W'(1)));
    // R7: a low-byte write replaces the low byte and holds the high byte.
    a_r7_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && lo_wr) |=> (ptr_out[BYTE_W-1:0] == $past(sfr_wdata[BYTE_W-1:0]))
            && (ptr_out[PTR_W-1:BYTE_W] == $past(ptr_out[PTR_W-1:BYTE_W])));
    // R7: a high-byte write replaces the high byte and holds the low byte.
    a_r7_hi_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hi_wr) |=> (ptr_out[PTR_W-1:BYTE_W] == $past(sfr_wdata[BYTE_W-1:0]))
            && (ptr_out[BYTE_W-1:0] == $past(ptr_out[BYTE_W-1:0])));
    // R3: unknown addresses read as zero.
    a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_hit |-> sfr_rdata == 8'h00);
endmodule

// File: tb/dptr_bank_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes the expected ptr_out for
// each cycle, and a monitor at the falling edge pops and compares.
module dptr_bank_tb;
    localparam logic [7:0] A_SEL = 8'h92;
    localparam logic [7:0] A_LO  = 8'h82;
    localparam logic [7:0] A_HI  = 8'h83;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        sfr_hit;
    logic        ld_en = 1'b0;
    logic [15:0] ld_value = '0;
    logic        inc_en = 1'b0;
    logic [15:0] ptr_out;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [15:0] m_ptr [8];
    logic [2:0]  m_sel;

    always #2 clk = ~clk;

    dptr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
        .ld_en(ld_en), .ld_value(ld_value), .inc_en(inc_en), .ptr_out(ptr_out)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare ptr_out against the oldest expected item.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(ptr_out, e.v, e.tag);
        end
    end

    // Driver: one cycle of stimulus, with the model updated and the
    // expected ptr_out pushed.
    task automatic step(input logic we, input logic [7:0] addr, input logic [7:0] wd,
                        input logic ld, input logic [15:0] lv, input logic inc,
                        input string tag);
        logic [2:0] s;
        @(negedge clk); #1;
        sfr_we = we; sfr_addr = addr; sfr_wdata = wd;
        ld_en = ld; ld_value = lv; inc_en = inc;
        s = m_sel;
        if (we && addr == A_LO)      m_ptr[s][7:0]  = wd;
        else if (we && addr == A_HI) m_ptr[s][15:8] = wd;
        else if (ld)                 m_ptr[s]       = lv;
        else if (inc)                m_ptr[s]       = m_ptr[s] + 16'd1;
        if (we && addr == A_SEL)     m_sel          = wd[2:0];
        q.push_back('{m_ptr[m_sel], tag});
    endtask

    task automatic sel(input logic [2:0] n, input string tag);
        step(1'b1, A_SEL, {5'b10101, n}, 1'b0, 16'h0, 1'b0, tag);
    endtask

    task automatic load(input logic [15:0] v, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b1, v, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b0, tag);
    endtask

    // Readback check during an idle cycle.
    task automatic rd(input logic [7:0] addr, input logic [7:0] exp,
                      input logic exp_hit, input string tag);
        @(negedge clk); #1;
        sfr_we = 1'b0; ld_en = 1'b0; inc_en = 1'b0; sfr_addr = addr;
        #0.5;
        check({8'h00, sfr_rdata}, {8'h00, exp}, tag);
        check({15'h0, sfr_hit}, {15'h0, exp_hit}, {tag, " hit"});
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_ptr[i] = '0;
        m_sel = '0;
        // Hold inputs active during reset to show it dominates.
        sfr_we = 1'b1; sfr_addr = A_SEL; sfr_wdata = 8'h07; inc_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1; sfr_we = 1'b0; inc_en = 1'b0; sfr_addr = '0;
        #0.5;
        check(ptr_out, 16'h0000, "R1 ptr_out after reset");
        rd(A_SEL, 8'h00, 1'b1, "R1 select after reset");
        rd(A_LO,  8'h00, 1'b1, "R1 low byte after reset");
        rd(A_HI,  8'h00, 1'b1, "R1 high byte after reset");

        load(16'h1234, "R5 load pointer 0");
        rd(A_LO, 8'h34, 1'b1, "R3 low byte readback");
        rd(A_HI, 8'h12, 1'b1, "R3 high byte readback");
        rd(8'h81, 8'h00, 1'b0, "R3 foreign address");

        sel(3'd5, "R2 select 5 with upper bits set");
        rd(A_SEL, 8'h05, 1'b1, "R2 upper select bits read zero");
        load(16'hABCD, "R5 load pointer 5");
        sel(3'd0, "R4 pointer 0 kept");

        // Fill every pointer, then revisit all of them.
        for (int i = 0; i < 8; i++) begin
            sel(3'(i), "R2 switch");
            load(16'h1000 * i + 16'h0011 * i + 16'h0101, "R5 fill");
        end
        for (int i = 7; i >= 0; i--) sel(3'(i), "R4 revisit keeps value");

        load(16'h00FF, "R5 load before carry");
        step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, "R6 carry into high byte");
        load(16'hFFFF, "R5 load before wrap");
        step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, "R6 wrap to zero");
        step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, "R6 count after wrap");

        load(16'h5555, "R5 load before byte write");
        step(1'b1, A_LO, 8'h77, 1'b1, 16'h9999, 1'b1, "R7 low write beats load and inc");
        step(1'b1, A_HI, 8'h3C, 1'b0, 16'h0, 1'b1, "R7 high write beats inc");
        step(1'b1, A_HI, 8'hFF, 1'b1, 16'h2222, 1'b0, "R7 high write beats load");
        step(1'b0, 8'h00, 8'h00, 1'b1, 16'h4242, 1'b1, "R8 load beats inc");

        sel(3'd2, "R4 select 2");
        step(1'b1, A_SEL, 8'h06, 1'b1, 16'hBEEF, 1'b0, "R9 load goes to old pointer");
        sel(3'd2, "R9 old pointer took load");
        step(1'b1, A_SEL, 8'h03, 1'b0, 16'h0, 1'b1, "R9 inc goes to old pointer");
        sel(3'd2, "R9 old pointer incremented");
        sel(3'd6, "R4 pointer 6 untouched");
        sel(3'd3, "R4 pointer 3 untouched");
        step(1'b1, 8'h81, 8'h99, 1'b0, 16'h0, 1'b0, "R3 foreign write ignored");
        idle("R4 idle hold");
        idle("R4 idle hold");
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule